// File: doc/BRIEF.md
# Five-Class Bus Ownership Arbiter

This block decides which request source owns a shared bus for the next packet. Requests come from five classes: cache high priority, memory, display high priority, cache low priority, and display low priority. The classes are served in that order of strength. Each cache holds one high-priority slot and one low-priority slot. Each memory holds one slot. The display holds one slot of each priority. Inside the cache-high, cache-low and memory classes, three separate rotating pointers share the bus fairly among the members.

A request may win only after it has been held for a minimum number of bus cycles, set by the `min_wait` input. The arbiter keeps an age counter for every slot. The decision is taken on a clock edge where the packet sequencer raises `ready`, and it is presented registered one cycle later. The result is either a one-hot grant with a class code, or a no-grant pulse that the sequencer turns into a no-op packet.

Top module: `bus_class_arbiter`

## Requirements
- R1: The strongest class with an eligible request wins, in this order: cache high (class code 1), memory (2), display high (3), cache low (4), display low (5). Code 0 means no decision.
- R2: `grant` is one-hot or zero. Bit i stands for device id i. Memories use ids 0..NM-1, caches use ids NM..NM+NC-1, and the display uses id NM+NC. `no_grant` and a grant bit are never high together.
- R3: Inside the cache-high, memory and cache-low classes, the search starts at that class's pointer and wraps from the last member to the first. After a win, that class pointer moves to the member after the winner. The three pointers are independent.
- R4: A slot is eligible on an edge only if its request is high and its age before that edge is at least `min_wait`. The age is the number of earlier edges at which the request was high, counted since the request rose or since its last grant.
- R5: An age saturates at 2^CW-1 and does not wrap.
- R6: A slot's age returns to zero on the edge where that slot is granted, or on any edge where its request is low.
- R7: If `ready` is sampled high and no slot in any class is eligible, `no_grant` is high for the following cycle.
- R8: Decisions are taken only on edges where `ready` is high, and are shown one cycle later for one cycle. After an edge with `ready` low, `grant`, `grant_class` and `no_grant` are all zero, and pointers keep their values.
- R9: Reset sets all pointers to the first member of their class, clears all ages, and drives zero on all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | 1 | Sequencer asks for the next owner on this edge |
| cache_hi_req | input | NC | High-priority request per cache |
| cache_lo_req | input | NC | Low-priority request per cache |
| mem_req | input | NM | Request per memory |
| disp_hi_req | input | 1 | Display high-priority request |
| disp_lo_req | input | 1 | Display low-priority request |
| min_wait | input | CW | Minimum age before a request may win |
| grant | output | NM+NC+1 | One-hot owner, indexed by device id |
| grant_class | output | 3 | Class code of the winner |
| no_grant | output | 1 | Decision taken but nothing eligible |

## Verification
Each decision depends on the inputs held across one rising edge and shows up on the outputs right after that edge. The bench applies inputs at the falling edge and runs its reference model at the next falling edge, using the inputs that were present at the rising edge in between. It then compares the outputs at that same falling edge, so exactly one register stage sits between stimulus and check. Ages change at the same edge as the decision, which is why the model computes eligibility from the ages it held before updating them.

// File: rtl/bus_class_arbiter.sv
module bus_class_arbiter #(
  parameter int NC = 4,
  parameter int NM = 2,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ready,
  input  logic [NC-1:0]   cache_hi_req,
  input  logic [NC-1:0]   cache_lo_req,
  input  logic [NM-1:0]   mem_req,
  input  logic            disp_hi_req,
  input  logic            disp_lo_req,
  input  logic [CW-1:0]   min_wait,
  output logic [NM+NC:0]  grant,
  output logic [2:0]      grant_class,
  output logic            no_grant
);

  localparam int NDEV = NM + NC + 1;
  localparam int MW   = (NC > NM) ? NC : NM;
  localparam int PW   = (MW > 1) ? $clog2(MW) : 1;
  localparam logic [CW-1:0] AMAX = {CW{1'b1}};
  localparam logic [2:0] C_NONE = 3'd0, C_CHI = 3'd1, C_MEM = 3'd2,
                         C_DHI = 3'd3, C_CLO = 3'd4, C_DLO = 3'd5;

  function automatic int rr_find(input logic [MW-1:0] el, input int ptr, input int n);
    int res;
    res = -1;
    for (int k = 0; k < MW; k++) begin
      if (k < n && res < 0) begin
        int i;
        i = ptr + k;
        if (i >= n) i = i - n;
        if (el[i]) res = i;
      end
    end
    return res;
  endfunction

  function automatic logic [PW-1:0] after(input int i, input int n);
    return (i + 1 >= n) ? '0 : PW'(i + 1);
  endfunction

  function automatic logic [CW-1:0] age_next(input logic [CW-1:0] a, input logic req, input logic take);
    if (!req || take) return '0;
    return (a == AMAX) ? a : a + 1'b1;
  endfunction

  logic [CW-1:0] age_chi [NC];
  logic [CW-1:0] age_clo [NC];
  logic [CW-1:0] age_mem [NM];
  logic [CW-1:0] age_dhi, age_dlo;
  logic [NC-1:0] el_chi, el_clo, take_chi, take_clo;
  logic [NM-1:0] el_mem, take_mem;
  logic          el_dhi, el_dlo, el_any;
  logic [PW-1:0] ptr_chi, ptr_clo, ptr_mem;
  logic [2:0]    wcls;
  int            widx;
  logic [NDEV-1:0] wvec;

  for (genvar i = 0; i < NC; i++) begin : g_cache
    assign el_chi[i]   = cache_hi_req[i] && (age_chi[i] >= min_wait);
    assign el_clo[i]   = cache_lo_req[i] && (age_clo[i] >= min_wait);
    assign take_chi[i] = ready && (wcls == C_CHI) && (widx == i);
    assign take_clo[i] = ready && (wcls == C_CLO) && (widx == i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_chi[i] <= '0;
        age_clo[i] <= '0;
      end else begin
        age_chi[i] <= age_next(age_chi[i], cache_hi_req[i], take_chi[i]);
        age_clo[i] <= age_next(age_clo[i], cache_lo_req[i], take_clo[i]);
      end
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_mem
    assign el_mem[i]   = mem_req[i] && (age_mem[i] >= min_wait);
    assign take_mem[i] = ready && (wcls == C_MEM) && (widx == i);
    always_ff @(posedge clk) begin
      if (!rst_n) age_mem[i] <= '0;
      else        age_mem[i] <= age_next(age_mem[i], mem_req[i], take_mem[i]);
    end
  end

  assign el_dhi = disp_hi_req && (age_dhi >= min_wait);
  assign el_dlo = disp_lo_req && (age_dlo >= min_wait);
  assign el_any = (|el_chi) || (|el_mem) || el_dhi || (|el_clo) || el_dlo;

  always_comb begin
    int h_chi, h_mem, h_clo;
    h_chi = rr_find(MW'(el_chi), int'(ptr_chi), NC);
    h_mem = rr_find(MW'(el_mem), int'(ptr_mem), NM);
    h_clo = rr_find(MW'(el_clo), int'(ptr_clo), NC);
    wcls = C_NONE;
    widx = 0;
    if (h_chi >= 0)      begin wcls = C_CHI; widx = h_chi; end
    else if (h_mem >= 0) begin wcls = C_MEM; widx = h_mem; end
    else if (el_dhi)     wcls = C_DHI;
    else if (h_clo >= 0) begin wcls = C_CLO; widx = h_clo; end
    else if (el_dlo)     wcls = C_DLO;
    wvec = '0;
    case (wcls)
      C_CHI, C_CLO: wvec[NM + widx] = 1'b1;
      C_MEM:        wvec[widx] = 1'b1;
      C_DHI, C_DLO: wvec[NDEV-1] = 1'b1;
      default:      wvec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_dhi     <= '0;
      age_dlo     <= '0;
      ptr_chi     <= '0;
      ptr_clo     <= '0;
      ptr_mem     <= '0;
      grant       <= '0;
      grant_class <= C_NONE;
      no_grant    <= 1'b0;
    end else begin
      age_dhi <= age_next(age_dhi, disp_hi_req, ready && wcls == C_DHI);
      age_dlo <= age_next(age_dlo, disp_lo_req, ready && wcls == C_DLO);
      if (ready) begin
        grant       <= wvec;
        grant_class <= wcls;
        no_grant    <= (wcls == C_NONE);
        if (wcls == C_CHI) ptr_chi <= after(widx, NC);
        if (wcls == C_CLO) ptr_clo <= after(widx, NC);
        if (wcls == C_MEM) ptr_mem <= after(widx, NM);
      end else begin
        grant       <= '0;
        grant_class <= C_NONE;
        no_grant    <= 1'b0;
      end
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && !(no_grant && |grant));

  // R1
  mem_below_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_class == C_MEM) |-> $past(el_chi) == '0);

  // R7
  none_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_grant |-> !$past(el_any));

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant || no_grant || grant_class != C_NONE) |-> $past(ready));

  // R5
  age_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(age_dhi) == AMAX && $past(disp_hi_req) && grant_class != C_DHI) |-> age_dhi == AMAX);

  for (genvar i = 0; i < NM; i++) begin : g_mem_chk
    // R4
    mem_aged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> $past(mem_req[i] && age_mem[i] >= min_wait));
  end

endmodule

// File: tb/test_bus_class_arbiter.sv
`timescale 1ns/1ps
module test_bus_class_arbiter;
  localparam int NC = 4, NM = 2, CW = 4, ND = NM + NC + 1;
  localparam int AMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, ready = 0;
  logic [NC-1:0] cache_hi_req = '0, cache_lo_req = '0;
  logic [NM-1:0] mem_req = '0;
  logic disp_hi_req = 0, disp_lo_req = 0;
  logic [CW-1:0] min_wait = '0;
  logic [ND-1:0] grant;
  logic [2:0] grant_class;
  logic no_grant;

  bus_class_arbiter #(.NC(NC), .NM(NM), .CW(CW)) i_bus_class_arbiter (
    .clk(clk), .rst_n(rst_n), .ready(ready), .cache_hi_req(cache_hi_req),
    .cache_lo_req(cache_lo_req), .mem_req(mem_req), .disp_hi_req(disp_hi_req),
    .disp_lo_req(disp_lo_req), .min_wait(min_wait), .grant(grant),
    .grant_class(grant_class), .no_grant(no_grant));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int a_chi[NC], a_clo[NC], a_mem[NM], a_dhi, a_dlo;
  int p_chi, p_clo, p_mem;
  logic [ND-1:0] e_grant;
  int e_cls;
  bit e_ng;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rr(input logic [7:0] el, input int p, input int n);
    for (int k = 0; k < n; k++) begin
      int i = (p + k) % n;
      if (el[i]) return i;
    end
    return -1;
  endfunction

  function automatic int age_upd(input int a, input bit req, input bit take);
    if (!req || take) return 0;
    return (a == AMAX) ? a : a + 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NC; i++) begin a_chi[i] = 0; a_clo[i] = 0; end
    for (int i = 0; i < NM; i++) a_mem[i] = 0;
    a_dhi = 0; a_dlo = 0; p_chi = 0; p_clo = 0; p_mem = 0;
  endtask

  task automatic model_step();
    logic [7:0] el_chi = 0, el_clo = 0, el_mem = 0;
    int h, idx = 0;
    int lat = int'(min_wait);
    for (int i = 0; i < NC; i++) begin
      el_chi[i] = cache_hi_req[i] && a_chi[i] >= lat;
      el_clo[i] = cache_lo_req[i] && a_clo[i] >= lat;
    end
    for (int i = 0; i < NM; i++) el_mem[i] = mem_req[i] && a_mem[i] >= lat;
    e_grant = '0; e_cls = 0; e_ng = 0;
    if (ready) begin
      if ((h = rr(el_chi, p_chi, NC)) >= 0) begin e_cls = 1; idx = h; e_grant[NM+h] = 1; p_chi = (h + 1) % NC; end
      else if ((h = rr(el_mem, p_mem, NM)) >= 0) begin e_cls = 2; idx = h; e_grant[h] = 1; p_mem = (h + 1) % NM; end
      else if (disp_hi_req && a_dhi >= lat) begin e_cls = 3; e_grant[ND-1] = 1; end
      else if ((h = rr(el_clo, p_clo, NC)) >= 0) begin e_cls = 4; idx = h; e_grant[NM+h] = 1; p_clo = (h + 1) % NC; end
      else if (disp_lo_req && a_dlo >= lat) begin e_cls = 5; e_grant[ND-1] = 1; end
      else e_ng = 1;
    end
    for (int i = 0; i < NC; i++) begin
      a_chi[i] = age_upd(a_chi[i], cache_hi_req[i], e_cls == 1 && idx == i);
      a_clo[i] = age_upd(a_clo[i], cache_lo_req[i], e_cls == 4 && idx == i);
    end
    for (int i = 0; i < NM; i++) a_mem[i] = age_upd(a_mem[i], mem_req[i], e_cls == 2 && idx == i);
    a_dhi = age_upd(a_dhi, disp_hi_req, e_cls == 3);
    a_dlo = age_upd(a_dlo, disp_lo_req, e_cls == 5);
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    chk(grant_class == 3'(e_cls), "R1 class", grant_class, e_cls);
    chk(grant == e_grant, "R3 grant vector", grant, e_grant);
    chk(no_grant == e_ng, "R7 no_grant", no_grant, e_ng);
    chk($onehot0(grant) && !(no_grant && |grant), "R2 one-hot", grant, 0);
  endtask

  task automatic clear_reqs();
    cache_hi_req = '0; cache_lo_req = '0; mem_req = '0;
    disp_hi_req = 0; disp_lo_req = 0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(grant == '0 && !no_grant && grant_class == 0, "R9 reset outputs", grant, 0);
    rst_n = 1;
    cyc();
    chk(grant == '0 && !no_grant, "R9 idle after reset", grant, 0);

    // R1 all classes requesting, min_wait 0: cache high wins from pointer 0
    min_wait = 0; ready = 1;
    cache_hi_req = '1; cache_lo_req = '1; mem_req = '1; disp_hi_req = 1; disp_lo_req = 1;
    cyc();
    chk(grant_class == 1 && grant[NM] == 1, "R1 cache high first", grant_class, 1);
    cyc();
    chk(grant[NM+1] == 1, "R3 cache high rotates", grant, 1 << (NM + 1));
    // R1 drop cache high: memory next, then display high, cache low, display low
    cache_hi_req = '0;
    cyc();
    chk(grant_class == 2 && grant[0], "R1 memory second", grant_class, 2);
    mem_req = '0;
    cyc();
    chk(grant_class == 3 && grant[ND-1], "R2 display id", grant, 1 << (ND - 1));
    disp_hi_req = 0;
    cyc();
    chk(grant_class == 4 && grant[NM], "R1 cache low fourth", grant_class, 4);
    cache_lo_req = '0;
    cyc();
    chk(grant_class == 5, "R1 display low last", grant_class, 5);
    clear_reqs();
    cyc();
    chk(no_grant == 1 && grant == '0, "R7 nothing pending", no_grant, 1);

    // R8 ready low blocks decisions
    ready = 0; mem_req = '1;
    cyc();
    chk(grant == '0 && !no_grant && grant_class == 0, "R8 ready low idle", grant, 0);
    clear_reqs();
    cyc();

    // R4 latency gating
    min_wait = 3; ready = 1; mem_req = 2'b10;
    cyc(); cyc(); cyc();
    chk(no_grant == 1, "R4 young request held off", no_grant, 1);
    cyc();
    chk(grant[1] == 1, "R4 aged request wins", grant, 2);
    // R6 age cleared by grant
    cyc();
    chk(no_grant == 1, "R6 age restarts after grant", no_grant, 1);
    clear_reqs(); ready = 0;
    cyc();

    // R5 saturation
    min_wait = CW'(AMAX); disp_lo_req = 1;
    repeat (AMAX + 6) cyc();
    ready = 1;
    cyc();
    chk(grant_class == 5 && grant[ND-1], "R5 saturated age stays eligible", grant_class, 5);
    // R6 withdrawal clears age
    ready = 0; disp_lo_req = 0; min_wait = 2;
    cyc();
    disp_lo_req = 1; ready = 1;
    cyc();
    chk(no_grant == 1, "R6 withdrawn request restarts age", no_grant, 1);
    clear_reqs();
    cyc();

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      if (n % 200 == 0) min_wait = CW'($urandom_range(0, 5));
      for (int i = 0; i < NC; i++) begin
        if ($urandom_range(0, 3) == 0) cache_hi_req[i] = ~cache_hi_req[i];
        if ($urandom_range(0, 3) == 0) cache_lo_req[i] = ~cache_lo_req[i];
      end
      for (int i = 0; i < NM; i++) if ($urandom_range(0, 3) == 0) mem_req[i] = ~mem_req[i];
      if ($urandom_range(0, 5) == 0) disp_hi_req = ~disp_hi_req;
      if ($urandom_range(0, 3) == 0) disp_lo_req = ~disp_lo_req;
      ready = ($urandom_range(0, 9) < 7);
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule